// File: doc/BRIEF.md
# Linear Sensor Readout Sequencer

This block is the digital timing core of a two-section linear image sensor with 256 pixels in one line. A single-clock start pulse on the first serial input is shifted through a 128-stage chain in section 1. From it the block derives a global hold strobe, an integrator-reset window and a one-hot pixel select. When the pulse leaves section 1 it appears on that section's serial output. In the normal serial connection that output is wired to the second section's serial input, and the pulse then walks through section 2 in the same way.

Each section has an output-enable that marks when its analog output would be driven. The enable is raised as the pulse enters the section and dropped one edge after the pulse reaches the last stage. A binary pixel index with a valid flag runs beside the selects. A start request that arrives while a readout is in progress raises an overlap error and is discarded. The analog parts (photodiodes, integrators, sample capacitors and the amplifier) are represented only by the select and enable outputs.

Edges are counted from the clock edge that accepts the start pulse, which is edge 1. "After edge k" means the value held in the cycle that follows that edge. All requirements assume that `so1_o` is wired to `si2_i`.

Top module: `lsr_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the shift chains, the hold strobe, the reset window, both output enables, both serial outputs, the valid flag and the overlap flag.
- R2: When `si1_i` is high at an edge while no readout is in progress, a readout starts. `hold_o` is high for exactly one cycle, after edge 1.
- R3: `int_rst_o` is high after edges 1 through 18 and low from edge 19 on.
- R4: After edge k (1..256), exactly bit k-1 of the 256-bit vector {`sel2_o`,`sel1_o`} is set. Pixels are therefore selected in ascending order, with section 1 at bits 0..127.
- R5: `so1_o` is high only after edge 128.
- R6: `oe1_o` is high after edges 1..128 and low after edge 129. `oe2_o` is high after edges 129..256 and low after edge 257.
- R7: `so2_o` is high only after edge 256 and is low again after edge 257.
- R8: The combined select vector never has more than one bit set, and `oe1_o` and `oe2_o` are never high together.
- R9: `pix_vld_o` is high after edges 1..256, and while it is high `pix_idx_o` equals k-1.
- R10: If `si1_i` is high at an edge while a readout is in progress (after edges 1..256), `ovl_err_o` is high for the following cycle. No hold is raised and the readout continues unchanged.
- R11: A start request at edge 257 is still an overlap. A request at the edge after that starts a new readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| si1_i | input | 1 | Start pulse for section 1 |
| si2_i | input | 1 | Start pulse for section 2 (normally from so1_o) |
| hold_o | output | 1 | Global hold strobe, one cycle |
| int_rst_o | output | 1 | Integrator reset window |
| sel1_o | output | 128 | One-hot pixel select, section 1 |
| sel2_o | output | 128 | One-hot pixel select, section 2 |
| oe1_o | output | 1 | Output enable, section 1 |
| oe2_o | output | 1 | Output enable, section 2 |
| so1_o | output | 1 | Serial output of section 1 |
| so2_o | output | 1 | Serial output of section 2 |
| pix_idx_o | output | 8 | Binary index of the selected pixel |
| pix_vld_o | output | 1 | Pixel index valid |
| ovl_err_o | output | 1 | Overlapping start request seen |

## Verification
The first pattern is an isolated start pulse followed by idle cycles. It shows the whole walk through both sections, the section hand-off at edges 128 and 129, and the final release at edge 257. A second start placed in the middle of a readout, and starts placed at edges 257 and 258, separate a correct busy window from one that ends a cycle early or late. A reset issued during a readout shows that all state clears. Sparse random start pulses, mixed with held-high bursts, compare every output on every cycle against an edge-count reference model.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
    // number of cascaded sections in one sensor line
    localparam int unsigned NUM_SEC = 2;

    // width of a binary index covering every pixel of the line
    function automatic int unsigned idx_width(input int unsigned sec_pix);
        return $clog2(NUM_SEC * sec_pix);
    endfunction
endpackage

// File: rtl/lsr_chain.sv
module lsr_chain #(
    parameter int unsigned N = 128
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    output logic [N-1:0] sel_o,
    output logic         so_o,
    output logic         oe_o
);
    typedef struct packed {
        logic [N-1:0] chain;
        logic         oe;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[N-2:0], start_i};
        if (start_i) begin
            s_d.oe = 1'b1;
        end else if (s_q.chain[N-1]) begin
            s_d.oe = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sel_o = s_q.chain;
    assign so_o  = s_q.chain[N-1];
    assign oe_o  = s_q.oe;

    // R8: the chain holds at most one token
    p_chain_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(s_q.chain));

    // R6: enable drops on the edge after the serial output was high
    p_oe_release_r6: assert property (@(posedge clk) disable iff (rst)
        (so_o && !start_i) |=> !oe_o);

    // R4: an entering token lands in stage 0 with the enable raised
    p_entry_r4: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (sel_o[0] && oe_o));
endmodule

// File: rtl/lsr_ctrl.sv
module lsr_ctrl #(
    parameter int unsigned RST_CLKS = 18
) (
    input  logic clk,
    input  logic rst,
    input  logic si1_i,
    input  logic busy_i,
    output logic start_o,
    output logic hold_o,
    output logic int_rst_o,
    output logic ovl_err_o
);
    localparam int unsigned CW = $clog2(RST_CLKS + 1);

    typedef struct packed {
        logic          hold;
        logic [CW-1:0] cnt;
        logic          err;
    } st_t;

    st_t  s_d, s_q;
    logic start;

    assign start = si1_i && !busy_i;

    always_comb begin
        s_d      = s_q;
        s_d.hold = start;
        s_d.err  = si1_i && busy_i;
        if (start) begin
            s_d.cnt = CW'(RST_CLKS);
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign start_o   = start;
    assign hold_o    = s_q.hold;
    assign int_rst_o = (s_q.cnt != '0);
    assign ovl_err_o = s_q.err;

    // R2 R3: an accepted start raises hold and the reset window
    p_start_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (si1_i && !busy_i) |=> (hold_o && int_rst_o));

    // R10: a start while busy flags overlap and raises no hold
    p_overlap_r10: assert property (@(posedge clk) disable iff (rst)
        (si1_i && busy_i) |=> (ovl_err_o && !hold_o));

    // R2: hold lasts one cycle only
    p_hold_single_r2: assert property (@(posedge clk) disable iff (rst)
        hold_o |=> !hold_o);
endmodule

// File: rtl/lsr_idx.sv
module lsr_idx #(
    parameter int unsigned TOTAL = 256
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     restart_i,
    input  logic                     adv_i,
    output logic [$clog2(TOTAL)-1:0] idx_o
);
    localparam int unsigned IW = $clog2(TOTAL);
    localparam logic [IW-1:0] LAST = IW'(TOTAL - 1);

    typedef struct packed {
        logic [IW-1:0] idx;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (restart_i) begin
            s_d.idx = '0;
        end else if (adv_i && (s_q.idx != LAST)) begin
            s_d.idx = s_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign idx_o = s_q.idx;

    // R9: a restart always returns the index to zero
    p_restart_zero_r9: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (idx_o == '0));
endmodule

// File: rtl/lsr_seq.sv
module lsr_seq #(
    parameter int unsigned SEC_PIX  = 128,
    parameter int unsigned RST_CLKS = 18
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic                                      si1_i,
    input  logic                                      si2_i,
    output logic                                      hold_o,
    output logic                                      int_rst_o,
    output logic [SEC_PIX-1:0]                        sel1_o,
    output logic [SEC_PIX-1:0]                        sel2_o,
    output logic                                      oe1_o,
    output logic                                      oe2_o,
    output logic                                      so1_o,
    output logic                                      so2_o,
    output logic [lsr_pkg::idx_width(SEC_PIX)-1:0]    pix_idx_o,
    output logic                                      pix_vld_o,
    output logic                                      ovl_err_o
);
    import lsr_pkg::*;

    localparam int unsigned TOTAL = NUM_SEC * SEC_PIX;

    logic [NUM_SEC-1:0] sec_start;
    logic [NUM_SEC-1:0] sec_so;
    logic [NUM_SEC-1:0] sec_oe;
    logic [SEC_PIX-1:0] sec_sel [NUM_SEC];
    logic               start;
    logic               busy;

    assign busy = |sec_oe;

    lsr_ctrl #(.RST_CLKS(RST_CLKS)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .si1_i    (si1_i),
        .busy_i   (busy),
        .start_o  (start),
        .hold_o   (hold_o),
        .int_rst_o(int_rst_o),
        .ovl_err_o(ovl_err_o)
    );

    assign sec_start[0] = start;
    assign sec_start[1] = si2_i;

    for (genvar g = 0; g < NUM_SEC; g++) begin : g_sec
        lsr_chain #(.N(SEC_PIX)) u_chain (
            .clk    (clk),
            .rst    (rst),
            .start_i(sec_start[g]),
            .sel_o  (sec_sel[g]),
            .so_o   (sec_so[g]),
            .oe_o   (sec_oe[g])
        );
    end

    lsr_idx #(.TOTAL(TOTAL)) u_idx (
        .clk      (clk),
        .rst      (rst),
        .restart_i(start),
        .adv_i    (busy),
        .idx_o    (pix_idx_o)
    );

    assign sel1_o    = sec_sel[0];
    assign sel2_o    = sec_sel[1];
    assign oe1_o     = sec_oe[0];
    assign oe2_o     = sec_oe[1];
    assign so1_o     = sec_so[0];
    assign so2_o     = sec_so[1];
    assign pix_vld_o = busy;

    // R8: the two sections never drive at once
    p_single_oe_r8: assert property (@(posedge clk) disable iff (rst)
        !(oe1_o && oe2_o));

    // R9: the index points at the selected pixel
    p_idx_sel_r9: assert property (@(posedge clk) disable iff (rst)
        pix_vld_o |-> {sel2_o, sel1_o}[pix_idx_o]);

    // R2: hold coincides with the first pixel of section 1
    p_hold_first_r2: assert property (@(posedge clk) disable iff (rst)
        hold_o |-> (sel1_o[0] && oe1_o));
endmodule

// File: tb/lsr_seq_tb.sv
module lsr_seq_tb;
    localparam int PER = 10;
    localparam int SP  = 128;
    localparam int TOT = 256;
    localparam int RW  = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          si1 = 1'b0;
    logic          hold, int_rst, oe1, oe2, so1, so2, vld, ovl;
    logic [SP-1:0] sel1, sel2;
    logic [7:0]    idx;

    int total = 0;
    int bad   = 0;
    int k     = 0;
    bit e_err = 1'b0;

    always #(PER/2) clk = ~clk;

    lsr_seq u_dut (
        .clk(clk), .rst(rst), .si1_i(si1), .si2_i(so1),
        .hold_o(hold), .int_rst_o(int_rst), .sel1_o(sel1), .sel2_o(sel2),
        .oe1_o(oe1), .oe2_o(oe2), .so1_o(so1), .so2_o(so2),
        .pix_idx_o(idx), .pix_vld_o(vld), .ovl_err_o(ovl)
    );

    task automatic chk(input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [255:0] exp_sel(input int kk);
        logic [255:0] v = '0;
        if (kk >= 1 && kk <= TOT) v[kk-1] = 1'b1;
        return v;
    endfunction

    task automatic check_all();
        bool_chk();
        chk("R4", "sel", {sel2, sel1}, exp_sel(k));
        if (k >= 1 && k <= TOT) chk("R9", "idx", 256'(idx), 256'(k - 1));
    endtask

    task automatic bool_chk();
        chk("R2", "hold", 256'(hold), 256'(k == 1));
        chk("R3", "int_rst", 256'(int_rst), 256'(k >= 1 && k <= RW));
        chk("R5", "so1", 256'(so1), 256'(k == SP));
        chk("R6", "oe1", 256'(oe1), 256'(k >= 1 && k <= SP));
        chk("R6", "oe2", 256'(oe2), 256'(k > SP && k <= TOT));
        chk("R7", "so2", 256'(so2), 256'(k == TOT));
        chk("R9", "vld", 256'(vld), 256'(k >= 1 && k <= TOT));
        chk("R10", "ovl", 256'(ovl), 256'(e_err));
        chk("R8", "oe_excl", 256'(oe1 && oe2), 256'(0));
        chk("R8", "sel_count", 256'($countones({sel2, sel1}) <= 1), 256'(1));
    endtask

    // reference model: k = edges since accept, 0 = idle
    task automatic step(input bit s);
        si1 = s;
        @(posedge clk);
        e_err = 1'b0;
        if (s && k == 0) begin
            k = 1;
        end else begin
            if (s) e_err = 1'b1;
            k = (k == 0 || k == TOT) ? 0 : k + 1;
        end
        @(negedge clk);
        check_all();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        si1 = 1'b0;
        @(posedge clk);
        k = 0;
        e_err = 1'b0;
        @(negedge clk);
        chk("R1", "sel", {sel2, sel1}, '0);
        chk("R1", "flags", 256'({hold, int_rst, oe1, oe2, so1, so2, vld, ovl}), '0);
        rst = 1'b0;
    endtask

    initial begin
        #(PER * 190000);
        bad++;
        total++;
        $display("FAIL R1 watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1402));
        @(negedge clk);
        do_reset();
        // isolated full readout
        step(1'b1);
        for (int i = 0; i < 300; i++) step(1'b0);
        // overlap in mid readout (R10)
        step(1'b1);
        for (int i = 0; i < 40; i++) step(1'b0);
        step(1'b1);
        chk("R10", "overlap flag", 256'(ovl), 256'(1));
        while (k != TOT) step(1'b0);
        // R11: request at edge 257 rejected, at 258 accepted
        step(1'b1);
        chk("R11", "edge257 overlap", 256'(ovl), 256'(1));
        chk("R11", "edge257 idle", 256'(oe2), 256'(0));
        step(1'b1);
        chk("R11", "edge258 hold", 256'(hold), 256'(1));
        // reset in mid readout (R1)
        for (int i = 0; i < 150; i++) step(1'b0);
        do_reset();
        for (int i = 0; i < 5; i++) step(1'b0);
        // random starts with occasional held-high bursts
        for (int i = 0; i < 6000; i++) begin
            int r = $urandom % 200;
            if (r < 3) begin
                for (int j = 0; j < 2 + ($urandom % 4); j++) step(1'b1);
            end else begin
                step(r < 6);
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule